// File: doc/BRIEF.md
# Flat Multi-Channel Register Decoder

This block sits between a CPU bus and a bank of up to eight serial channels. One active-low chip select and eight address lines serve the whole device. Address bit 7 low selects a channel window: bits 6:4 pick the channel and bits 3:0 pick one of sixteen registers. No register is banked behind a special line-control value. The one exception is the divisor pair at offsets 0 and 1, which the channel exposes while its own latch-enable bit is set. The decoder flags that case to the channel. Address bit 7 high with bits 6:4 at zero selects the shared configuration region, which holds the device-wide registers.

The configuration region has five writable or readable entries:
- a self-clearing software reset, one bit per channel;
- a sleep mask;
- an 8X sampling select;
- a broadcast enable;
- a read-only identity byte and revision byte.

While broadcast is on, one CPU write to a control register of any channel strobes every channel at once. Writes to data or status registers still go only to the addressed channel. Reads go to channel 0.

A small access state machine turns a level-held request into exactly one strobe cycle. Its states are IDLE, STROBE and HOLD. The transitions are:
- IDLE to STROBE when a request is seen;
- STROBE to HOLD unconditionally;
- HOLD back to IDLE once the request is withdrawn.

Read data from the channel or the configuration region is captured at the end of STROBE and stays on the output until the next read.

Top module: `flat_reg_decoder`

## Requirements
- R1: A request (cs_n low with wr_en or rd_en high; wr_en wins if both) seen at a clock edge gives exactly one strobe cycle on ch_wr or ch_rd, starting after that edge. No further strobe occurs until the request has been withdrawn for at least one edge.
- R2: With addr[7]=0, the strobe goes to channel addr[6:4] and ch_idx carries addr[3:0]. A write also carries its data on ch_wdata.
- R3: A channel read returns that channel's ch_rdata byte on rdata. It is valid from the edge ending the strobe cycle until the next read is captured.
- R4: The following addresses read 0x00, raise no strobe and ignore writes: 0x80 region offsets other than 0x0-0x3, 0xC and 0xD, and all of 0x90-0xFF.
- R5: Address 0x81 holds the sleep mask and 0x82 the 8X select, one bit per channel (bit n is channel n). Both are readable and drive ch_sleep and ch_8x from the edge ending the write strobe.
- R6: Writing 1 to bit n of address 0x80 pulses ch_rst[n] high for exactly one cycle, from the edge ending the write strobe. 0x80 always reads 0x00.
- R7: Bit 0 of address 0x83 enables broadcast. While it is set, a channel write to a control offset (1, 2, 3, 4, 7, 8, 9, 10 or 11) strobes ch_wr on every channel.
- R8: While broadcast is set, a channel write to a data or status offset (0, 5, 6, 12-15) strobes only the addressed channel.
- R9: While broadcast is set, any channel read strobes and returns channel 0 only.
- R10: Address 0x8C reads the identity byte (default 0x28) and 0x8D the revision byte (default 0x03). Writes to them have no effect.
- R11: ch_dl_sel[n] is high exactly when ch_dlab[n] is set and ch_idx is 0 or 1.
- R12: After reset, no strobe or reset pulse is active, sleep, 8X and broadcast are clear, and rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low device select |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 8 | Flat register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Captured read data |
| ch_rdata | input | NCH*8 | Read byte from each channel, channel n at bits n*8+7:n*8 |
| ch_dlab | input | NCH | Latch-enable bit of each channel |
| ch_wr | output | NCH | Per-channel write strobe |
| ch_rd | output | NCH | Per-channel read strobe |
| ch_idx | output | 4 | Register offset within the channel window |
| ch_wdata | output | 8 | Write data to the channels |
| ch_dl_sel | output | NCH | Divisor register selected, per channel |
| ch_rst | output | NCH | One-cycle software reset, per channel |
| ch_sleep | output | NCH | Sleep request, per channel |
| ch_8x | output | NCH | 8X sampling select, per channel |

## Verification
The hardest case to reach is broadcast mode, because it needs configuration state that only a prior write creates. The stimulus must first set bit 0 of 0x83. It then aims writes at one channel across both control and status offsets and checks the full strobe vector each time. Next it issues a read to a channel other than 0, then clears the enable and repeats a write to show the effect is gone. A request held low for several cycles is used to show that a single access yields a single strobe.

// File: rtl/frd_pkg.sv
package frd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2
    } acc_state_t;

    localparam logic [3:0] CFG_RESET = 4'h0;
    localparam logic [3:0] CFG_SLEEP = 4'h1;
    localparam logic [3:0] CFG_X8    = 4'h2;
    localparam logic [3:0] CFG_BCAST = 4'h3;
    localparam logic [3:0] CFG_ID    = 4'hC;
    localparam logic [3:0] CFG_REV   = 4'hD;
endpackage

// File: rtl/frd_access_fsm.sv
module frd_access_fsm
    import frd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       stb_wr,
    output logic       stb_rd,
    output logic [7:0] addr_q,
    output logic [7:0] wdata_q
);
    acc_state_t state, state_nx;
    logic       req;
    logic       wr_q;

    assign req = !cs_n && (rd_en || wr_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (state == ST_IDLE && req) begin
            addr_q  <= addr;
            wdata_q <= wdata;
            wr_q    <= wr_en;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req) state_nx = ST_STROBE;
            ST_STROBE: state_nx = ST_HOLD;
            ST_HOLD:   if (!req) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        stb_wr = 1'b0;
        stb_rd = 1'b0;
        unique case (state)
            ST_STROBE: begin
                stb_wr = wr_q;
                stb_rd = !wr_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/frd_cfg_regs.sv
module frd_cfg_regs
    import frd_pkg::*;
#(
    parameter int         NCH     = 8,
    parameter logic [7:0] DEV_ID  = 8'h28,
    parameter logic [7:0] DEV_REV = 8'h03
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [3:0]     offset,
    input  logic [7:0]     wdata,
    output logic [7:0]     cfg_rdata,
    output logic [NCH-1:0] rst_pulse,
    output logic [NCH-1:0] sleep_q,
    output logic [NCH-1:0] x8_q,
    output logic           bcast_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pulse <= '0;
            sleep_q   <= '0;
            x8_q      <= '0;
            bcast_q   <= 1'b0;
        end else begin
            rst_pulse <= '0;
            if (cfg_wr) begin
                unique case (offset)
                    CFG_RESET: rst_pulse <= wdata[NCH-1:0];
                    CFG_SLEEP: sleep_q   <= wdata[NCH-1:0];
                    CFG_X8:    x8_q      <= wdata[NCH-1:0];
                    CFG_BCAST: bcast_q   <= wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (offset)
            CFG_SLEEP: cfg_rdata = 8'(sleep_q);
            CFG_X8:    cfg_rdata = 8'(x8_q);
            CFG_BCAST: cfg_rdata = {7'd0, bcast_q};
            CFG_ID:    cfg_rdata = DEV_ID;
            CFG_REV:   cfg_rdata = DEV_REV;
            default:   cfg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/frd_chan_decode.sv
module frd_chan_decode #(
    parameter int          NCH        = 8,
    parameter logic [15:0] BCAST_MASK = 16'h0F9E
) (
    input  logic [7:0]     addr_q,
    input  logic           stb_wr,
    input  logic           stb_rd,
    input  logic           bcast,
    input  logic [NCH-1:0] dlab,
    output logic [NCH-1:0] ch_wr,
    output logic [NCH-1:0] ch_rd,
    output logic [NCH-1:0] dl_sel,
    output logic           is_chan,
    output logic           is_cfg,
    output logic [2:0]     rd_chan
);
    logic [2:0] chan_sel;
    logic [3:0] idx;
    logic       bc_hit;

    assign chan_sel = addr_q[6:4];
    assign idx      = addr_q[3:0];
    assign is_chan  = !addr_q[7] && ({1'b0, chan_sel} < 4'(NCH));
    assign is_cfg   = addr_q[7] && (chan_sel == 3'd0);
    assign bc_hit   = bcast && BCAST_MASK[idx];
    assign rd_chan  = bcast ? 3'd0 : chan_sel;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_wr[n]  = stb_wr && is_chan && ((chan_sel == 3'(n)) || bc_hit);
        assign ch_rd[n]  = stb_rd && is_chan && (rd_chan == 3'(n));
        assign dl_sel[n] = dlab[n] && (idx < 4'd2);
    end
endmodule

// File: rtl/flat_reg_decoder.sv
module flat_reg_decoder #(
    parameter int          NCH        = 8,
    parameter logic [7:0]  DEV_ID     = 8'h28,
    parameter logic [7:0]  DEV_REV    = 8'h03,
    parameter logic [15:0] BCAST_MASK = 16'h0F9E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [NCH*8-1:0] ch_rdata,
    input  logic [NCH-1:0]   ch_dlab,
    output logic [NCH-1:0]   ch_wr,
    output logic [NCH-1:0]   ch_rd,
    output logic [3:0]       ch_idx,
    output logic [7:0]       ch_wdata,
    output logic [NCH-1:0]   ch_dl_sel,
    output logic [NCH-1:0]   ch_rst,
    output logic [NCH-1:0]   ch_sleep,
    output logic [NCH-1:0]   ch_8x
);
    logic       stb_wr, stb_rd, is_chan, is_cfg, bcast;
    logic [7:0] addr_q, wdata_q, cfg_rdata, chan_byte, rdata_q;
    logic [2:0] rd_chan;
    logic [7:0] chan_bytes [NCH];

    frd_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .stb_wr(stb_wr), .stb_rd(stb_rd),
        .addr_q(addr_q), .wdata_q(wdata_q)
    );

    frd_chan_decode #(.NCH(NCH), .BCAST_MASK(BCAST_MASK)) u_dec (
        .addr_q(addr_q), .stb_wr(stb_wr), .stb_rd(stb_rd), .bcast(bcast),
        .dlab(ch_dlab), .ch_wr(ch_wr), .ch_rd(ch_rd), .dl_sel(ch_dl_sel),
        .is_chan(is_chan), .is_cfg(is_cfg), .rd_chan(rd_chan)
    );

    frd_cfg_regs #(.NCH(NCH), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(stb_wr && is_cfg),
        .offset(addr_q[3:0]), .wdata(wdata_q), .cfg_rdata(cfg_rdata),
        .rst_pulse(ch_rst), .sleep_q(ch_sleep), .x8_q(ch_8x), .bcast_q(bcast)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_unpack
        assign chan_bytes[n] = ch_rdata[n*8 +: 8];
    end

    always_comb begin
        chan_byte = 8'h00;
        for (int n = 0; n < NCH; n++)
            if (rd_chan == 3'(n)) chan_byte = chan_bytes[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= 8'h00;
        else if (stb_rd) rdata_q <= is_chan ? chan_byte : (is_cfg ? cfg_rdata : 8'h00);
    end

    assign rdata    = rdata_q;
    assign ch_idx   = addr_q[3:0];
    assign ch_wdata = wdata_q;
endmodule

// File: rtl/flat_reg_decoder_chk.sv
module flat_reg_decoder_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic           rd_en,
    input logic           wr_en,
    input logic [NCH-1:0] ch_wr,
    input logic [NCH-1:0] ch_rd,
    input logic [NCH-1:0] ch_rst,
    input logic [NCH-1:0] ch_sleep
);
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_wr) || (|ch_rd)) |=> (ch_wr == '0 && ch_rd == '0)); // R1
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_wr) |-> $past(!cs_n && wr_en)); // R1
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_rst) |=> (ch_rst == '0)); // R6
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rd)); // R9
    AST_SLEEP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_sleep) |-> $past(!cs_n && wr_en, 2)); // R5
endmodule

bind flat_reg_decoder flat_reg_decoder_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en(rd_en), .wr_en(wr_en),
    .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_rst(ch_rst), .ch_sleep(ch_sleep)
);

// File: tb/flat_reg_decoder_test.sv
module flat_reg_decoder_test;
    localparam int NCH = 8;

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp_wr;
        logic [7:0] exp_rd;
        logic [7:0] exp_rdata;
        logic [3:0] req;
    } vec_t;

    // reads of channel n return 8'hC0|n from the channel model below
    localparam vec_t VECS [16] = '{
        '{1'b1, 8'h23, 8'h55, 8'h04, 8'h00, 8'h00, 4'd2},  // R2 write ch2
        '{1'b0, 8'h35, 8'h00, 8'h00, 8'h08, 8'hC3, 4'd3},  // R3 read ch3
        '{1'b0, 8'h7F, 8'h00, 8'h00, 8'h80, 8'hC7, 4'd2},  // R2 last channel
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'hC0, 4'd2},  // R2 first channel
        '{1'b1, 8'h81, 8'hA5, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 sleep write
        '{1'b0, 8'h81, 8'h00, 8'h00, 8'h00, 8'hA5, 4'd5},  // R5 sleep read
        '{1'b1, 8'h82, 8'h0F, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 8X write
        '{1'b0, 8'h82, 8'h00, 8'h00, 8'h00, 8'h0F, 4'd5},  // R5 8X read
        '{1'b0, 8'h8C, 8'h00, 8'h00, 8'h00, 8'h28, 4'd10}, // R10 id
        '{1'b1, 8'h8C, 8'hFF, 8'h00, 8'h00, 8'h00, 4'd10}, // R10 write id
        '{1'b0, 8'h8C, 8'h00, 8'h00, 8'h00, 8'h28, 4'd10}, // R10 id unchanged
        '{1'b0, 8'h8D, 8'h00, 8'h00, 8'h00, 8'h03, 4'd10}, // R10 revision
        '{1'b0, 8'h8E, 8'h00, 8'h00, 8'h00, 8'h00, 4'd4},  // R4 unused cfg
        '{1'b1, 8'hF3, 8'h77, 8'h00, 8'h00, 8'h00, 4'd4},  // R4 write above map
        '{1'b0, 8'hF3, 8'h00, 8'h00, 8'h00, 8'h00, 4'd4},  // R4 read above map
        '{1'b0, 8'h83, 8'h00, 8'h00, 8'h00, 8'h00, 4'd4}   // R4 no alias into 0x83
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]       addr = '0, wdata = '0, rdata;
    logic [NCH*8-1:0] ch_rdata;
    logic [NCH-1:0]   ch_dlab = '0;
    logic [NCH-1:0]   ch_wr, ch_rd, ch_dl_sel, ch_rst, ch_sleep, ch_8x;
    logic [3:0]       ch_idx;
    logic [7:0]       ch_wdata;

    int applied = 0, miscompares = 0;
    logic [7:0] g_wr, g_rd, g_dl, g_wdata, g_rdata, g_rst, g_rst_after;
    logic [3:0] g_idx;

    always #10 clk = ~clk;

    for (genvar n = 0; n < NCH; n++) begin : g_model
        assign ch_rdata[n*8 +: 8] = 8'hC0 | 8'(n);
    end

    flat_reg_decoder #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ch_rdata(ch_rdata),
        .ch_dlab(ch_dlab), .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_idx(ch_idx),
        .ch_wdata(ch_wdata), .ch_dl_sel(ch_dl_sel), .ch_rst(ch_rst),
        .ch_sleep(ch_sleep), .ch_8x(ch_8x)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        applied++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_en = wr; rd_en = !wr; addr = a; wdata = d;
        @(negedge clk);
        g_wr = ch_wr; g_rd = ch_rd; g_idx = ch_idx; g_dl = ch_dl_sel; g_wdata = ch_wdata;
        @(negedge clk);
        g_rdata = rdata; g_rst = ch_rst;
        cs_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        g_rst_after = ch_rst;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 strobes", {ch_wr, ch_rd, ch_rst}, 24'h0);
        check("R12 sleep/8x", {ch_sleep, ch_8x}, 16'h0);
        check("R12 rdata", rdata, 8'h00);

        for (int i = 0; i < 16; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            applied++;
            if (g_wr !== VECS[i].exp_wr || g_rd !== VECS[i].exp_rd ||
                (!VECS[i].wr && g_rdata !== VECS[i].exp_rdata) ||
                ((g_wr != 0 || g_rd != 0) && g_idx !== VECS[i].addr[3:0]) ||
                (g_wr != 0 && g_wdata !== VECS[i].wdata)) begin
                miscompares++;
                $display("FAIL R%0d vec %0d: got wr=%h rd=%h rdata=%h idx=%h expected wr=%h rd=%h rdata=%h idx=%h",
                         VECS[i].req, i, g_wr, g_rd, g_rdata, g_idx,
                         VECS[i].exp_wr, VECS[i].exp_rd, VECS[i].exp_rdata, VECS[i].addr[3:0]);
            end
        end
        check("R5 sleep output", ch_sleep, 8'hA5);
        check("R5 8x output", ch_8x, 8'h0F);

        // R6 reset pulse
        access(1'b1, 8'h80, 8'h12);
        check("R6 pulse", g_rst, 8'h12);
        check("R6 pulse ends", g_rst_after, 8'h00);
        access(1'b0, 8'h80, 8'h00);
        check("R6 reads zero", g_rdata, 8'h00);

        // R7 / R8 / R9 broadcast
        access(1'b1, 8'h83, 8'h01);
        access(1'b1, 8'h53, 8'h3C);
        check("R7 control offset all", g_wr, 8'hFF);
        check("R7 data", g_wdata, 8'h3C);
        access(1'b1, 8'h18, 8'h00);
        check("R7 enhanced control all", g_wr, 8'hFF);
        access(1'b1, 8'h50, 8'h11);
        check("R8 data offset", g_wr, 8'h20);
        access(1'b1, 8'h55, 8'h11);
        check("R8 status offset", g_wr, 8'h20);
        access(1'b1, 8'h5E, 8'h11);
        check("R8 high status offset", g_wr, 8'h20);
        access(1'b0, 8'h64, 8'h00);
        check("R9 read strobe", g_rd, 8'h01);
        check("R9 read data", g_rdata, 8'hC0);
        access(1'b1, 8'h83, 8'h00);
        access(1'b1, 8'h53, 8'h3C);
        check("R7 off again", g_wr, 8'h20);

        // R11 divisor flag
        ch_dlab = 8'h05;
        access(1'b1, 8'h21, 8'h01);
        check("R11 offset 1", g_dl, 8'h05);
        access(1'b1, 8'h23, 8'h01);
        check("R11 offset 3", g_dl, 8'h00);
        ch_dlab = 8'h00;

        // R1 held request gives one strobe
        begin
            int strobes = 0;
            @(negedge clk);
            cs_n = 1'b0; wr_en = 1'b1; addr = 8'h12; wdata = 8'h99;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (ch_wr != 0) strobes++;
            end
            cs_n = 1'b1; wr_en = 1'b0;
            repeat (2) @(negedge clk);
            check("R1 held request strobes", strobes, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule